// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a byte-wide parallel flash. Software or a sequencer first issues the command writes for a program or an erase. After the final command write it pulses `start_i`. The block then reads the target location over and over through a request/acknowledge read port. From the status bits in each returned byte it decides when the embedded operation inside the flash has ended.

Two polling methods are supported, and the caller picks one per job:

- **Bit-7 polling.** The block compares bit 7 of each read against the expected value for the operation.
- **Bit-6 toggle detection.** The block compares bit 6 of two back-to-back reads.

Under both methods, bit 5 acts as the device's over-time flag. After completion is seen, one more full read is taken, because the other data bits can lag behind the status bit. That read is the byte handed back. The outcome is a one-cycle `done_o` or `fail_o` pulse, and `busy_o` covers the whole job.

For an erase, the caller must point the read port at an address inside a sector being erased. Polling must begin only after the last write of the command sequence; for a chip erase that is the sixth write. Both are the caller's duty.

Top module: `flash_done_poller`

## Requirements
- R1: A `start_i` pulse while idle latches the operation type, the method, the expected byte and the poll budget, and raises `busy_o`. `rd_req_o` then stays high until `rd_ack_i` is seen, and `rd_data_i` is taken only in cycles with `rd_ack_i` high.
- R2: With bit-7 polling for a program (`op_erase_i`=0, `mode_toggle_i`=0), a read is complete when its bit 7 equals bit 7 of `exp_data_i`.
- R3: With bit-7 polling for an erase (`op_erase_i`=1, `mode_toggle_i`=0), a read is complete when its bit 7 is 1.
- R4: With toggle detection (`mode_toggle_i`=1), a read is complete when its bit 6 equals bit 6 of the read just before it in the same job. The first read of a job is never complete.
- R5: If a polling read is not complete and its bit 5 is 1, exactly one recheck read follows. If the recheck is complete the job goes on to the confirming read; otherwise `fail_o` pulses. The recheck does not use the poll budget.
- R6: Each polling read that is not complete and has bit 5 at 0 uses one unit of the budget `max_polls_i`. When the budget is used up, `fail_o` pulses. A budget of 0 acts as 1.
- R7: After a complete read, one confirming read is made and its byte appears on `data_o` in the cycle the result pulses. For an erase, the result is `done_o`.
- R8: For a program, a confirming byte that differs from `exp_data_i` in any bit gives `fail_o`; an equal byte gives `done_o`.
- R9: `done_o` and `fail_o` are one-cycle pulses, never high together, and `busy_o` is low in the cycle either of them is high.
- R10: `start_i` has no effect while `busy_o` is high.
- R11: After reset, `busy_o`, `done_o`, `fail_o` and `rd_req_o` are 0 and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (one-cycle pulse) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_toggle_i | input | 1 | 1 = bit-6 toggle detection, 0 = bit-7 polling |
| exp_data_i | input | 8 | Byte that was programmed |
| max_polls_i | input | CNT_W | Poll budget (0 acts as 1) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_ack_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Byte returned by the flash |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Success pulse |
| fail_o | output | 1 | Failure pulse |
| data_o | output | 8 | Byte from the confirming read |

## Verification
The bench builds the block with `CNT_W` = 4, so the whole budget range can be reached in a short run. That includes the zero budget and budgets smaller than the number of busy reads the flash model returns. The model's read latency is random between zero and two cycles. The status bytes it returns carry random filler in the unused bits. That exercises the confirming read, a status byte whose polled bit already matches while the other bits are stale, and recheck reads that land just as the operation finishes.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int BYTE_W  = 8;
  localparam int DQ_POLL = 7;
  localparam int DQ_TGL  = 6;
  localparam int DQ_LIM  = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_RECHK = 2'd2,
    ST_CONF  = 2'd3
  } poll_st_e;

  typedef struct packed {
    logic              erase;
    logic              toggle;
    logic [BYTE_W-1:0] expect_byte;
  } job_t;
endpackage

// File: rtl/flash_poll_eval.sv
module flash_poll_eval (
  input  logic erase_i,
  input  logic toggle_i,
  input  logic exp_poll_i,
  input  logic cur_poll_i,
  input  logic cur_tgl_i,
  input  logic cur_lim_i,
  input  logic prev_tgl_i,
  input  logic prev_ok_i,
  output logic complete_o,
  output logic over_time_o
);
  logic poll_ok;
  logic tgl_ok;

  always_comb begin
    poll_ok     = erase_i ? cur_poll_i : (cur_poll_i == exp_poll_i);
    tgl_ok      = prev_ok_i && (cur_tgl_i == prev_tgl_i);
    complete_o  = toggle_i ? tgl_ok : poll_ok;
    over_time_o = cur_lim_i;
  end
endmodule

// File: rtl/flash_poll_budget.sv
module flash_poll_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             step_i,
  output logic             exhausted_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W:0]   cnt_next;
  logic [CNT_W:0]   lim_eff;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (clr_i) begin
      cnt_d = '0;
      lim_d = lim_i;
    end else if (step_i) begin
      cnt_d = cnt_q + 1'b1;
    end
    cnt_next    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    lim_eff     = (lim_q == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, lim_q};
    exhausted_o = (cnt_next >= lim_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clr_i || step_i) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic              mode_toggle_i,
  input  logic [BYTE_W-1:0] exp_data_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [BYTE_W-1:0] data_o
);
  poll_st_e          st_q, st_d;
  job_t              job_q, job_d;
  logic              prev_tgl_q, prev_tgl_d;
  logic              prev_ok_q, prev_ok_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;
  logic              cnt_clr, cnt_step, exhausted;
  logic              complete, over_time;

  flash_poll_eval u_eval (
    .erase_i     (job_q.erase),
    .toggle_i    (job_q.toggle),
    .exp_poll_i  (job_q.expect_byte[DQ_POLL]),
    .cur_poll_i  (rd_data_i[DQ_POLL]),
    .cur_tgl_i   (rd_data_i[DQ_TGL]),
    .cur_lim_i   (rd_data_i[DQ_LIM]),
    .prev_tgl_i  (prev_tgl_q),
    .prev_ok_i   (prev_ok_q),
    .complete_o  (complete),
    .over_time_o (over_time)
  );

  flash_poll_budget #(.CNT_W(CNT_W)) u_budget (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (cnt_clr),
    .lim_i       (max_polls_i),
    .step_i      (cnt_step),
    .exhausted_o (exhausted)
  );

  always_comb begin
    st_d       = st_q;
    job_d      = job_q;
    prev_tgl_d = prev_tgl_q;
    prev_ok_d  = prev_ok_q;
    data_d     = data_q;
    done_d     = 1'b0;
    fail_d     = 1'b0;
    cnt_clr    = 1'b0;
    cnt_step   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          job_d.erase       = op_erase_i;
          job_d.toggle      = mode_toggle_i;
          job_d.expect_byte = exp_data_i;
          prev_ok_d         = 1'b0;
          cnt_clr           = 1'b1;
          st_d              = ST_POLL;
        end
      end
      ST_POLL: begin
        if (rd_ack_i) begin
          prev_tgl_d = rd_data_i[DQ_TGL];
          prev_ok_d  = 1'b1;
          if (complete) begin
            st_d = ST_CONF;
          end else if (over_time) begin
            st_d = ST_RECHK;
          end else begin
            cnt_step = 1'b1;
            if (exhausted) begin
              fail_d = 1'b1;
              st_d   = ST_IDLE;
            end
          end
        end
      end
      ST_RECHK: begin
        if (rd_ack_i) begin
          prev_tgl_d = rd_data_i[DQ_TGL];
          prev_ok_d  = 1'b1;
          if (complete) begin
            st_d = ST_CONF;
          end else begin
            fail_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      ST_CONF: begin
        if (rd_ack_i) begin
          data_d = rd_data_i;
          if (!job_q.erase && (rd_data_i != job_q.expect_byte)) begin
            fail_d = 1'b1;
          end else begin
            done_d = 1'b1;
          end
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      job_q      <= '0;
      prev_tgl_q <= 1'b0;
      prev_ok_q  <= 1'b0;
      data_q     <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      fail_q <= fail_d;
      if (st_q == ST_IDLE) begin
        job_q <= job_d;
      end
      if (rd_ack_i || (st_q == ST_IDLE)) begin
        prev_tgl_q <= prev_tgl_d;
        prev_ok_q  <= prev_ok_d;
      end
      if (st_q == ST_CONF) begin
        data_q <= data_d;
      end
    end
  end

  assign rd_req_o = (st_q != ST_IDLE);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign data_o   = data_q;
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req_o,
  input logic rd_ack_i,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);

  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || fail_o));

  a_r9_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> !busy_o);
endmodule

bind flash_done_poller flash_poll_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req_o (rd_req_o),
  .rd_ack_i (rd_ack_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .fail_o   (fail_o)
);

// File: tb/flash_done_poller_test.sv
module flash_done_poller_test;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          op_erase_i = 1'b0;
  logic          mode_toggle_i = 1'b0;
  logic [7:0]    exp_data_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic          rd_req_o;
  logic          rd_ack_i = 1'b0;
  logic [7:0]    rd_data_i = '0;
  logic          busy_o, done_o, fail_o;
  logic [7:0]    data_o;

  int errors = 0;
  int checks = 0;

  // scenario seen by the flash model
  logic       sc_erase, sc_tgl;
  logic [7:0] sc_exp, sc_final;
  int         sc_n, sc_to;
  int         rd_idx = 0;
  int         wait_cnt = 0;

  flash_done_poller #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .mode_toggle_i(mode_toggle_i), .exp_data_i(exp_data_i),
    .max_polls_i(max_polls_i), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .data_o(data_o)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] model(int k);
    logic [7:0] b;
    if (k >= sc_n) return sc_final;
    b = 8'((k * 37 + 11) ^ sc_exp ^ 8'h5A);
    b[7] = sc_erase ? 1'b0 : ~sc_exp[7];
    b[6] = k[0];
    b[5] = (sc_to >= 0) && (k >= sc_to);
    return b;
  endfunction

  // reference algorithm written from the requirements
  function automatic void predict(input int maxp, output logic ok,
                                  output int reads, output logic conf,
                                  output logic [7:0] cbyte);
    logic [7:0] d, prev;
    logic have_prev = 1'b0, rechk = 1'b0, comp;
    int polls = 0;
    int lim = (maxp == 0) ? 1 : maxp;
    int k = 0;
    prev = '0;
    ok = 1'b0; conf = 1'b0; cbyte = '0;
    for (int guard = 0; guard < 64; guard++) begin
      d = model(k); k++;
      comp = sc_tgl ? (have_prev && d[6] == prev[6])
                    : (sc_erase ? d[7] : (d[7] == sc_exp[7]));
      prev = d; have_prev = 1'b1;
      if (comp) begin
        cbyte = model(k); k++; conf = 1'b1;
        ok = sc_erase || (cbyte == sc_exp);
        break;
      end
      if (rechk) break;
      if (d[5]) begin rechk = 1'b1; continue; end
      polls++;
      if (polls >= lim) break;
    end
    reads = k;
  endfunction

  // flash read responder, random latency 0..2
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ack_i) begin
        rd_ack_i = 1'b0;
      end else if (rd_req_o) begin
        if (wait_cnt == 0) begin
          rd_data_i = model(rd_idx);
          rd_idx++;
          rd_ack_i = 1'b1;
          wait_cnt = int'($urandom % 3);
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic check(input logic cond, input string req,
                       input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_case(input logic er, input logic tg, input logic [7:0] ex,
                          input int maxp, input int n, input int to,
                          input logic [7:0] fin, input logic poke, input string req);
    logic ok, conf;
    int reads, cyc;
    logic [7:0] cb;
    logic got_done, got_fail;
    sc_erase = er; sc_tgl = tg; sc_exp = ex; sc_n = n; sc_to = to; sc_final = fin;
    rd_idx = 0;
    predict(maxp, ok, reads, conf, cb);
    @(negedge clk);
    start_i = 1'b1; op_erase_i = er; mode_toggle_i = tg;
    exp_data_i = ex; max_polls_i = CW'(maxp);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, {req, " R1 busy"}, busy_o, 1);
    if (poke) begin
      // R10: a second start with different settings while busy
      start_i = 1'b1; op_erase_i = ~er; mode_toggle_i = ~tg;
      exp_data_i = ~ex; max_polls_i = '0;
      @(negedge clk);
      start_i = 1'b0;
    end
    got_done = 1'b0; got_fail = 1'b0; cyc = 0;
    while (!(done_o || fail_o) && cyc < 500) begin
      @(negedge clk); cyc++;
    end
    if (cyc >= 500) begin
      check(1'b0, {req, " watchdog"}, cyc, 0);
      return;
    end
    got_done = done_o; got_fail = fail_o;
    check(got_done == ok && got_fail == !ok, {req, " outcome(done)"}, got_done, ok);
    check(busy_o == 1'b0, {req, " R9 busy low"}, busy_o, 0);
    check(rd_idx == reads, {req, " read count"}, rd_idx, reads);
    if (conf) check(data_o == cb, {req, " R7 data"}, data_o, cb);
    @(negedge clk);
    check(!done_o && !fail_o, {req, " R9 pulse"}, {done_o, fail_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !fail_o && !rd_req_o && data_o == 8'h00,
          "R11 reset", {busy_o, done_o, fail_o, rd_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corner cases
    run_case(1'b0, 1'b0, 8'hA5, 10, 3, -1, 8'hA5, 1'b0, "R2 program poll");
    run_case(1'b0, 1'b0, 8'h3C, 10, 0, -1, 8'h3C, 1'b0, "R2 immediate");
    run_case(1'b1, 1'b0, 8'h00, 10, 2, -1, 8'hFF, 1'b0, "R3 erase poll");
    run_case(1'b1, 1'b1, 8'h00, 10, 4, -1, 8'hFF, 1'b0, "R4 toggle erase");
    run_case(1'b0, 1'b1, 8'h12, 10, 0, -1, 8'h12, 1'b0, "R4 toggle first read");
    run_case(1'b0, 1'b0, 8'h81, 10, 3, 2, 8'h81, 1'b0, "R5 recheck completes");
    run_case(1'b1, 1'b0, 8'h00, 10, 6, 1, 8'hFF, 1'b0, "R5 recheck fails");
    run_case(1'b0, 1'b0, 8'h81, 2, 6, -1, 8'h81, 1'b0, "R6 budget");
    run_case(1'b0, 1'b0, 8'h81, 0, 6, -1, 8'h81, 1'b0, "R6 zero budget");
    run_case(1'b0, 1'b0, 8'hC3, 10, 2, -1, 8'hC2, 1'b0, "R8 mismatch");
    run_case(1'b0, 1'b0, 8'h47, 10, 3, -1, 8'h47, 1'b1, "R10 start ignored");
    // constrained random
    for (int i = 0; i < 150; i++) begin
      logic er, tg;
      logic [7:0] ex, fin;
      int n, to, mp;
      er = 1'($urandom);
      tg = 1'($urandom);
      ex = 8'($urandom);
      n  = int'($urandom % 7);
      to = ($urandom % 3 == 0) ? int'($urandom % (n + 1)) : -1;
      mp = int'($urandom % 12);
      fin = 8'($urandom);
      if ($urandom % 2 == 0) fin = er ? (fin | 8'h80) : ex;
      run_case(er, tg, ex, mp, n, to, fin, 1'($urandom % 8 == 0), "R2 R3 R4 R5 R6 R8 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    $urandom(32'd1234);
  end
endmodule